// File: doc/BRIEF.md
# Exception Entry State Capture Unit

This block performs the register-side work of entering an exception handler. When `take_exc` is strobed, it looks at the exception code, the program counter, the current machine state word and a few core configuration inputs. From these it produces a registered result: the return address and saved state word for the save/restore pair, the machine state word the handler starts with, and the handler's vector address. A `done` pulse marks the cycle in which the new values are visible.

The unit also keeps a power-save flag, which `pm_enter` sets. If a non-machine-check exception arrives while the flag is set, the exception becomes a wakeup:

- the flag is cleared;
- a resume marker and a 4-bit reason code are written into the saved state word;
- the exception is steered to the reset handler.

Configurations that cannot be honoured raise `cfg_err` alongside `done`. These are an undefined vector, a hypervisor-class exception on a core without hypervisor support, and an unsupported wakeup source.

Bit numbers below use little-endian numbering (bit 0 is the least significant bit of a 64-bit word). The state-word bits are: LE=0, DR=4, IR=5, ME=12, ILE=16, HV=60.

Top module: `exc_entry_capture`

## Requirements
- R1: Exception codes are RESET=0, MCHECK=1, DSTOR=2, ISTOR=3, EXT=4, ALIGN=5, PROG=6, SYSCALL=7, DECR=8, DBELL=9, HDBELL=10, HMAINT=11, HDECR=12, HDSTOR=13, CRIT=14, DEBUG=15. Codes 2, 3, 5, 6 and 13 save `pc-4` as the return address. All other codes save `pc`.
- R2: For core_kind values 0, 2 and 3, the saved state is `cur_state` with the bits of 0x783F0000 cleared. For core_kind 1 (embedded), the saved state is `cur_state` unchanged.
- R3: The new state word starts from only the ME and HV bits of `cur_state`. MCHECK clears ME. HV is set for codes 10–13, and also for RESET and MCHECK when `hv_present` is 1.
- R4: When the power-save flag is set and any code other than MCHECK is taken, the exception is handled as RESET (vector, return address and HV rules) and the flag is cleared. In the saved state, bits 21:16 are replaced: bit 16 is set to 1 and bits 21:18 carry the reason code. When MCHECK is taken in power-save, it is handled normally and leaves the flag set. `pm_enter` sets the flag, and it takes precedence over a clear in the same cycle.
- R5: The wakeup reason codes are: RESET 0x4, EXT 0x8, DECR 0x6, DBELL 0x5, HDBELL 0x3, HMAINT 0xA. Any other source waking the core raises `cfg_err`.
- R6: With `alt_pair_en`=1, an MCHECK or DEBUG entry also writes the same return address and saved state into the alternate pair. All other entries leave the alternate pair unchanged.
- R7: The vector is the code's offset ORed with `vec_prefix`. The offsets by code 0..15 are: 0x100, 0x200, 0x300, 0x400, 0x500, 0x600, 0x700, 0xC00, 0x900, 0xA00, 0xE80, 0xEA0, 0x980, 0xE00, 0xF00, 0xD00.
- R8: When relocation applies, the vector is the offset ORed with 0xC000000000004000 in place of the prefix, and IR and DR are set in the new state.
- R9: Relocation applies only when `reloc_en` is 1, `cur_state` has both IR and DR set, and the entry does not move HV from 0 to 1.
- R10: The new state's LE bit is chosen by core_kind:
  - kinds 0 and 1: the ILE bit of `cur_state`;
  - kind 2: `part_ile` when the new HV is 0, otherwise 0;
  - kind 3: `hv_ile` when the new HV is 1, otherwise `part_ile`.
- R11: `cfg_err` is 1 when the vector entry of the handled code is marked undefined in `vec_undef`, or when a code in 10–13 is requested with `hv_present`=0.
- R12: `done` is high exactly in the cycle after `take_exc`. All outputs hold their values between entries.
- R13: After reset, all outputs and the power-save flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_exc | input | 1 | Strobe: capture an exception entry |
| exc_code | input | CODE_W (4) | Exception code (R1 encoding) |
| pc | input | XLEN (64) | Next-instruction address |
| cur_state | input | XLEN (64) | Current machine state word |
| core_kind | input | 2 | 0 classic, 1 embedded, 2 server A, 3 server B |
| hv_present | input | 1 | Core implements hypervisor state |
| part_ile | input | 1 | Partition-level little-endian handler select |
| hv_ile | input | 1 | Hypervisor little-endian handler select |
| reloc_en | input | 1 | Vector relocation mode active |
| alt_pair_en | input | 1 | Alternate save pair configured |
| vec_prefix | input | XLEN (64) | Global vector prefix |
| vec_undef | input | 2**CODE_W (16) | Per-code undefined-vector marks |
| pm_enter | input | 1 | Enter power-save |
| save_addr | output | XLEN (64) | Saved return address |
| save_state | output | XLEN (64) | Saved state word |
| alt_addr | output | XLEN (64) | Alternate pair return address |
| alt_state | output | XLEN (64) | Alternate pair state word |
| new_state | output | XLEN (64) | Handler machine state word |
| handler_vec | output | XLEN (64) | Handler vector address |
| done | output | 1 | Entry result valid pulse |
| cfg_err | output | 1 | Illegal configuration for the last entry |
| in_powersave | output | 1 | Power-save flag |

## Verification
The bench concentrates on the wakeup path, on relocation suppression and on the endianness choice per core kind.

- **Wakeup.** A wakeup that kept the original vector would point at the wrong handler. One that forgot to clear the flag would turn every later exception into a wakeup. One that also woke on a machine check would lose the pending power-save. The bench covers all six reason codes and an unsupported source, and checks that a stale ILE bit in the reason field is overwritten.
- **Relocation.** The bench drives relocation with translation off and with a rise into hypervisor state. A design that ignored either condition would return the 0xC000000000004000 base and set IR/DR where it must not.
- **Alternate pair.** The bench checks both that the pair mirrors on MCHECK and DEBUG and that it is left untouched on a storage fault.

// File: rtl/exc_entry_capture.sv
module exc_entry_capture #(
  parameter int XLEN = 64,
  parameter int CODE_W = 4,
  parameter logic [63:0] RELOC_BASE = 64'hC000_0000_0000_4000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_exc,
  input  logic [CODE_W-1:0]       exc_code,
  input  logic [XLEN-1:0]         pc,
  input  logic [XLEN-1:0]         cur_state,
  input  logic [1:0]              core_kind,
  input  logic                    hv_present,
  input  logic                    part_ile,
  input  logic                    hv_ile,
  input  logic                    reloc_en,
  input  logic                    alt_pair_en,
  input  logic [XLEN-1:0]         vec_prefix,
  input  logic [(1<<CODE_W)-1:0]  vec_undef,
  input  logic                    pm_enter,
  output logic [XLEN-1:0]         save_addr,
  output logic [XLEN-1:0]         save_state,
  output logic [XLEN-1:0]         alt_addr,
  output logic [XLEN-1:0]         alt_state,
  output logic [XLEN-1:0]         new_state,
  output logic [XLEN-1:0]         handler_vec,
  output logic                    done,
  output logic                    cfg_err,
  output logic                    in_powersave
);

  localparam int B_LE   = 0;
  localparam int B_DR   = 4;
  localparam int B_IR   = 5;
  localparam int B_ME   = 12;
  localparam int B_ILE  = 16;
  localparam int B_WAKE = 16;
  localparam int B_RSN  = 18;
  localparam int B_HV   = XLEN - 4;
  localparam logic [XLEN-1:0] MBZ      = XLEN'(64'h783F_0000);
  localparam logic [XLEN-1:0] WAKE_FLD = XLEN'(6'h3F) << B_WAKE;

  localparam logic [CODE_W-1:0] EC_RESET  = CODE_W'(0);
  localparam logic [CODE_W-1:0] EC_MCHECK = CODE_W'(1);
  localparam logic [CODE_W-1:0] EC_DSTOR  = CODE_W'(2);
  localparam logic [CODE_W-1:0] EC_ISTOR  = CODE_W'(3);
  localparam logic [CODE_W-1:0] EC_EXT    = CODE_W'(4);
  localparam logic [CODE_W-1:0] EC_ALIGN  = CODE_W'(5);
  localparam logic [CODE_W-1:0] EC_PROG   = CODE_W'(6);
  localparam logic [CODE_W-1:0] EC_DECR   = CODE_W'(8);
  localparam logic [CODE_W-1:0] EC_DBELL  = CODE_W'(9);
  localparam logic [CODE_W-1:0] EC_HDBELL = CODE_W'(10);
  localparam logic [CODE_W-1:0] EC_HMAINT = CODE_W'(11);
  localparam logic [CODE_W-1:0] EC_HDECR  = CODE_W'(12);
  localparam logic [CODE_W-1:0] EC_HDSTOR = CODE_W'(13);
  localparam logic [CODE_W-1:0] EC_DEBUG  = CODE_W'(15);

  localparam logic [1:0] KIND_EMB  = 2'd1;
  localparam logic [1:0] KIND_SRVA = 2'd2;
  localparam logic [1:0] KIND_SRVB = 2'd3;

  function automatic logic hv_class(input logic [CODE_W-1:0] c);
    return (c == EC_HDBELL) || (c == EC_HMAINT) || (c == EC_HDECR) || (c == EC_HDSTOR);
  endfunction

  function automatic logic [15:0] vec_offset(input logic [CODE_W-1:0] c);
    case (c)
      4'd0:    return 16'h0100;
      4'd1:    return 16'h0200;
      4'd2:    return 16'h0300;
      4'd3:    return 16'h0400;
      4'd4:    return 16'h0500;
      4'd5:    return 16'h0600;
      4'd6:    return 16'h0700;
      4'd7:    return 16'h0C00;
      4'd8:    return 16'h0900;
      4'd9:    return 16'h0A00;
      4'd10:   return 16'h0E80;
      4'd11:   return 16'h0EA0;
      4'd12:   return 16'h0980;
      4'd13:   return 16'h0E00;
      4'd14:   return 16'h0F00;
      default: return 16'h0D00;
    endcase
  endfunction

  logic              ps_q;
  logic              wake;
  logic [3:0]        reason;
  logic              reason_ok;
  logic [CODE_W-1:0] eff;
  logic              raise_hv, cur_sync, hv_up, reloc, le, err_d, alt_wr;
  logic [XLEN-1:0]   addr_d, base_st, state_d, nst, nstate_d, vec_d;

  always_comb begin
    reason_ok = 1'b1;
    case (exc_code)
      EC_RESET:  reason = 4'h4;
      EC_EXT:    reason = 4'h8;
      EC_DECR:   reason = 4'h6;
      EC_DBELL:  reason = 4'h5;
      EC_HDBELL: reason = 4'h3;
      EC_HMAINT: reason = 4'hA;
      default: begin
        reason    = 4'h0;
        reason_ok = 1'b0;
      end
    endcase
  end

  assign wake     = ps_q && (exc_code != EC_MCHECK);
  assign eff      = wake ? EC_RESET : exc_code;
  assign raise_hv = hv_class(eff) || (hv_present && (eff == EC_MCHECK || eff == EC_RESET));
  assign cur_sync = (eff == EC_DSTOR) || (eff == EC_ISTOR) || (eff == EC_ALIGN) ||
                    (eff == EC_PROG)  || (eff == EC_HDSTOR);
  assign addr_d   = cur_sync ? pc - XLEN'(4) : pc;
  assign base_st  = (core_kind == KIND_EMB) ? cur_state : (cur_state & ~MBZ);
  assign state_d  = wake ? ((base_st & ~WAKE_FLD) | (XLEN'(1) << B_WAKE) | (XLEN'(reason) << B_RSN))
                         : base_st;

  always_comb begin
    nst       = '0;
    nst[B_ME] = cur_state[B_ME] && (eff != EC_MCHECK);
    nst[B_HV] = cur_state[B_HV] || raise_hv;
  end

  assign hv_up = nst[B_HV] && !cur_state[B_HV];
  assign reloc = reloc_en && cur_state[B_IR] && cur_state[B_DR] && !hv_up;

  always_comb begin
    case (core_kind)
      KIND_SRVA: le = !nst[B_HV] && part_ile;
      KIND_SRVB: le = nst[B_HV] ? hv_ile : part_ile;
      default:   le = cur_state[B_ILE];
    endcase
  end

  assign nstate_d = nst | (XLEN'(le) << B_LE) |
                    (reloc ? ((XLEN'(1) << B_IR) | (XLEN'(1) << B_DR)) : '0);
  assign vec_d    = XLEN'(vec_offset(eff)) | (reloc ? XLEN'(RELOC_BASE) : vec_prefix);
  assign err_d    = vec_undef[eff] || (hv_class(exc_code) && !hv_present) || (wake && !reason_ok);
  assign alt_wr   = alt_pair_en && (eff == EC_MCHECK || eff == EC_DEBUG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      save_addr   <= '0;
      save_state  <= '0;
      alt_addr    <= '0;
      alt_state   <= '0;
      new_state   <= '0;
      handler_vec <= '0;
      done        <= 1'b0;
      cfg_err     <= 1'b0;
      ps_q        <= 1'b0;
    end else begin
      done <= take_exc;
      if (take_exc) begin
        save_addr   <= addr_d;
        save_state  <= state_d;
        new_state   <= nstate_d;
        handler_vec <= vec_d;
        cfg_err     <= err_d;
        if (alt_wr) begin
          alt_addr  <= addr_d;
          alt_state <= state_d;
        end
      end
      if (pm_enter)
        ps_q <= 1'b1;
      else if (take_exc && wake)
        ps_q <= 1'b0;
    end
  end

  assign in_powersave = ps_q;

  a_r12_done_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> done);

  a_r12_done_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(take_exc));

  a_r4_wakeup_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_powersave && take_exc && exc_code != EC_MCHECK && !pm_enter) |=> !in_powersave);

  a_r4_mcheck_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_powersave && take_exc && exc_code == EC_MCHECK) |=> in_powersave);

  a_r3_mcheck_drops_me: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && exc_code == EC_MCHECK) |=> !new_state[B_ME]);

  a_r6_alt_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && alt_pair_en && (exc_code == EC_MCHECK || exc_code == EC_DEBUG))
      |=> (alt_addr == save_addr && alt_state == save_state));

  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |=> ($stable(save_addr) && $stable(handler_vec) && $stable(new_state)));

endmodule

// File: tb/exc_entry_capture_tb_top.sv
`timescale 1ns/1ps
module exc_entry_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_exc = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [63:0] pc = '0;
  logic [63:0] cur_state = '0;
  logic [1:0]  core_kind = '0;
  logic        hv_present = 1'b0;
  logic        part_ile = 1'b0;
  logic        hv_ile = 1'b0;
  logic        reloc_en = 1'b0;
  logic        alt_pair_en = 1'b0;
  logic [63:0] vec_prefix = '0;
  logic [15:0] vec_undef = '0;
  logic        pm_enter = 1'b0;
  logic [63:0] save_addr, save_state, alt_addr, alt_state, new_state, handler_vec;
  logic        done, cfg_err, in_powersave;

  always #2.5 clk = ~clk;

  exc_entry_capture dut_i (
    .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .exc_code(exc_code), .pc(pc),
    .cur_state(cur_state), .core_kind(core_kind), .hv_present(hv_present),
    .part_ile(part_ile), .hv_ile(hv_ile), .reloc_en(reloc_en), .alt_pair_en(alt_pair_en),
    .vec_prefix(vec_prefix), .vec_undef(vec_undef), .pm_enter(pm_enter),
    .save_addr(save_addr), .save_state(save_state), .alt_addr(alt_addr),
    .alt_state(alt_state), .new_state(new_state), .handler_vec(handler_vec),
    .done(done), .cfg_err(cfg_err), .in_powersave(in_powersave));

  typedef struct {
    logic [63:0] addr, st, nst, vec, alt_a, alt_s;
    logic        err, ps;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic        m_ps = 1'b0;
  logic [63:0] m_alt_a = '0, m_alt_s = '0, last_addr = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] off_of(input int c);
    logic [15:0] t [16] = '{16'h100, 16'h200, 16'h300, 16'h400, 16'h500, 16'h600, 16'h700, 16'hC00,
                             16'h900, 16'hA00, 16'hE80, 16'hEA0, 16'h980, 16'hE00, 16'hF00, 16'hD00};
    return t[c];
  endfunction

  task automatic apply(input string tag);
    exp_t e;
    logic wk, hvn, rl, le, rs_ok;
    logic [3:0] rs;
    int c;
    wk = m_ps && (exc_code != 4'd1);
    rs_ok = 1'b1;
    case (exc_code)
      4'd0: rs = 4'h4;   4'd4: rs = 4'h8;   4'd8: rs = 4'h6;
      4'd9: rs = 4'h5;   4'd10: rs = 4'h3;  4'd11: rs = 4'hA;
      default: begin rs = 4'h0; rs_ok = 1'b0; end
    endcase
    c = wk ? 0 : int'(exc_code);
    e.addr = (c == 2 || c == 3 || c == 5 || c == 6 || c == 13) ? pc - 64'd4 : pc;
    e.st = (core_kind == 2'd1) ? cur_state : (cur_state & ~64'h783F_0000);
    if (wk) e.st = (e.st & ~64'h003F_0000) | 64'h0001_0000 | (64'(rs) << 18);
    hvn = cur_state[60] || (c >= 10 && c <= 13) || (hv_present && (c == 0 || c == 1));
    case (core_kind)
      2'd2: le = !hvn && part_ile;
      2'd3: le = hvn ? hv_ile : part_ile;
      default: le = cur_state[16];
    endcase
    rl = reloc_en && cur_state[5] && cur_state[4] && !(hvn && !cur_state[60]);
    e.nst = '0;
    e.nst[12] = cur_state[12] && (c != 1);
    e.nst[60] = hvn;
    e.nst[0] = le;
    if (rl) begin e.nst[5] = 1'b1; e.nst[4] = 1'b1; end
    e.vec = 64'(off_of(c)) | (rl ? 64'hC000_0000_0000_4000 : vec_prefix);
    e.err = vec_undef[c] || (exc_code >= 4'd10 && exc_code <= 4'd13 && !hv_present) || (wk && !rs_ok);
    if (alt_pair_en && (c == 1 || c == 15)) begin m_alt_a = e.addr; m_alt_s = e.st; end
    e.alt_a = m_alt_a;
    e.alt_s = m_alt_s;
    if (wk) m_ps = 1'b0;
    e.ps = m_ps;
    e.tag = tag;
    sb.push_back(e);
    take_exc = 1'b1;
    @(negedge clk);
    take_exc = 1'b0;
    @(negedge clk);
  endtask

  task automatic enter_ps();
    pm_enter = 1'b1;
    @(negedge clk);
    pm_enter = 1'b0;
    m_ps = 1'b1;
    @(negedge clk);
    chk("R4", "ps flag after pm_enter", 64'(in_powersave), 64'd1);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R12", "done without strobe", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R1", {e.tag, " save_addr"}, save_addr, e.addr);
        chk("R2", {e.tag, " save_state"}, save_state, e.st);
        chk("R3", {e.tag, " new_state"}, new_state, e.nst);
        chk("R7", {e.tag, " handler_vec"}, handler_vec, e.vec);
        chk("R11", {e.tag, " cfg_err"}, 64'(cfg_err), 64'(e.err));
        chk("R6", {e.tag, " alt_addr"}, alt_addr, e.alt_a);
        chk("R6", {e.tag, " alt_state"}, alt_state, e.alt_s);
        chk("R4", {e.tag, " ps flag"}, 64'(in_powersave), 64'(e.ps));
        last_addr = e.addr;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "save_addr", save_addr, 64'd0);
    chk("R13", "new_state", new_state, 64'd0);
    chk("R13", "handler_vec", handler_vec, 64'd0);
    chk("R13", "done", 64'(done), 64'd0);
    chk("R13", "ps flag", 64'(in_powersave), 64'd0);

    vec_prefix = 64'h0000_0000_FFF0_0000;
    pc = 64'h0000_0000_0000_2000;
    cur_state = 64'h1000_0000_783F_1031;
    exc_code = 4'd2; apply("R1 R2 dstor classic");
    exc_code = 4'd7; apply("R1 syscall next");
    exc_code = 4'd6; apply("R1 prog current");

    core_kind = 2'd1; exc_code = 4'd4; apply("R2 embedded unmasked");
    core_kind = 2'd0;

    hv_present = 1'b1; alt_pair_en = 1'b1; cur_state = 64'h0000_0000_0000_1000;
    exc_code = 4'd1; pc = 64'h4440; apply("R3 R6 mcheck mirror");
    exc_code = 4'd2; pc = 64'h5550; apply("R6 dstor leaves alt");
    exc_code = 4'd15; pc = 64'h6660; apply("R6 debug mirror");
    alt_pair_en = 1'b0;

    cur_state = 64'h0000_0000_0000_1030; reloc_en = 1'b1;
    exc_code = 4'd8; apply("R8 decr relocated");
    cur_state = 64'h0000_0000_0000_1020;
    exc_code = 4'd8; apply("R9 no reloc when DR off");
    cur_state = 64'h0000_0000_0000_1030;
    exc_code = 4'd12; apply("R9 no reloc on hv rise");
    cur_state = 64'h1000_0000_0000_1030;
    exc_code = 4'd12; apply("R8 reloc already hv");
    reloc_en = 1'b0;

    cur_state = 64'h0000_0000_0001_0000; core_kind = 2'd0;
    exc_code = 4'd4; apply("R10 kind0 ile");
    core_kind = 2'd2; part_ile = 1'b1; cur_state = '0;
    exc_code = 4'd4; apply("R10 kind2 guest");
    exc_code = 4'd12; apply("R10 kind2 hv forces be");
    core_kind = 2'd3; part_ile = 1'b0; hv_ile = 1'b1;
    exc_code = 4'd12; apply("R10 kind3 hv ile");
    exc_code = 4'd4; apply("R10 kind3 part ile");
    core_kind = 2'd0; hv_ile = 1'b0;

    cur_state = 64'h0000_0000_0001_1000;
    enter_ps(); exc_code = 4'd8; pc = 64'h7770; apply("R4 R5 decr wake");
    enter_ps(); exc_code = 4'd1; apply("R4 mcheck in ps");
    exc_code = 4'd4; apply("R4 R5 ext wake");
    enter_ps(); exc_code = 4'd0; apply("R5 reset wake");
    enter_ps(); exc_code = 4'd9; apply("R5 dbell wake");
    enter_ps(); exc_code = 4'd10; apply("R5 hdbell wake");
    enter_ps(); exc_code = 4'd11; apply("R5 hmaint wake");
    enter_ps(); exc_code = 4'd7; apply("R5 syscall wake err");
    enter_ps(); exc_code = 4'd2; pc = 64'h8880; apply("R4 dstor wake uses next");

    vec_undef = 16'h0010; exc_code = 4'd4; apply("R11 undefined vector");
    vec_undef = '0;
    hv_present = 1'b0; exc_code = 4'd13; apply("R11 hv class without hv");
    exc_code = 4'd5; apply("R11 align ok");

    // R12 outputs hold while idle
    repeat (3) @(negedge clk);
    chk("R12", "done idle", 64'(done), 64'd0);
    chk("R12", "save_addr held", save_addr, last_addr);
    chk("R12", "scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end

endmodule